// File: doc/BRIEF.md
# Mark-Space Pulse Waveform Generator

This block produces a rectangular pulse waveform for a wideband converter whose fabric runs at a quarter of the sample rate. Each fabric clock cycle it emits one 64-bit word that holds four 16-bit samples. Lane 0 sits in bits 15:0 and is the earliest sample in time. The waveform alternates between a mark level and a space level. Each phase lasts a programmed whole number of fabric cycles. The mark can also spill over into the first space cycle by up to three single samples.

The levels are applied live, so a new level shows on the next output word. The mark count, space count and fine count are captured at the clock edge that opens each mark phase, so a change made mid-period takes effect from the following period. While the enable is low, the output words are zero, the generator sits at the start of the mark phase, and the durations are sampled at every edge.

Top module: `pulse_gen_top`

## Requirements
- R1: After reset the output word is zero.
- R2: An enable sampled low at a clock edge makes the output word all zero after that edge and returns the generator to the start of the mark phase.
- R3: Counting from the first edge that samples enable high, output words 0 to M-1 carry the mark level in all four lanes. M is the captured mark count. Lane i occupies bits 16*i+15 down to 16*i.
- R4: After the mark phase, S words follow that carry the space level, except for the fine lanes set by R5. S is the captured space count. The pattern then repeats with a period of M+S words.
- R5: In the first word of the space phase, lanes 0 to F-1 carry the mark level and lanes F to 3 carry the space level. F is the captured 2-bit fine count. When F is 0, the word is pure space.
- R6: A mark count or space count of zero acts as one cycle.
- R7: The mark, space and fine counts are captured at the edge that starts each mark phase. While the generator is disabled they are captured at every edge. Level inputs take effect on the next word.
- R8: Re-enabling after any disable restarts the waveform with a full mark phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rstN | input | 1 | Synchronous reset, active low |
| enable | input | 1 | Run the generator; low forces zero output and restart |
| markLevel | input | 16 | Sample value during the mark phase |
| spaceLevel | input | 16 | Sample value during the space phase |
| markCycles | input | 16 | Mark duration in fabric cycles (0 treated as 1) |
| spaceCycles | input | 16 | Space duration in fabric cycles (0 treated as 1) |
| fineCount | input | 2 | Extra mark samples in the first space word |
| sampleWord | output | 64 | Four samples, lane 0 in the low bits |

## Verification
The main function is tried with a table of duration sets. The sets include long marks with short spaces, the reverse, both counts at zero, and every fine value from 0 to 3. Each set is followed for two full periods, so a wrong period length or a wrong phase boundary shows up as a shift in the second period. Distinct mark and space levels per set make a lane-order or fine-mask error visible in the exact lane. Directed cases change the counts mid-period, to separate capture at the start of the mark from live use. They also change a level mid-mark and disable for a single cycle, which shows the restart.

// File: rtl/pulse_pkg.sv
package pulse_pkg;
  localparam int PG_LANES = 4;
  localparam int PG_FINE_W = $clog2(PG_LANES);

  typedef struct packed {
    logic                zeroOut;
    logic [PG_LANES-1:0] markLane;
  } pulse_strb_t;
endpackage

// File: rtl/pulse_ctrl.sv
module pulse_ctrl
  import pulse_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 enable,
  input  logic [CNT_W-1:0]     markCycles,
  input  logic [CNT_W-1:0]     spaceCycles,
  input  logic [PG_FINE_W-1:0] fineCount,
  output pulse_strb_t          strb
);
  logic                 inMark;
  logic [CNT_W-1:0]     idx;
  logic [CNT_W-1:0]     markLat, spaceLat;
  logic [PG_FINE_W-1:0] fineLat;
  logic [CNT_W-1:0]     markLast, spaceLast;

  // zero-length phases behave as one cycle
  assign markLast  = (markLat  == '0) ? '0 : markLat  - CNT_W'(1);
  assign spaceLast = (spaceLat == '0) ? '0 : spaceLat - CNT_W'(1);

  always_ff @(posedge clk) begin
    if (!rstN || !enable) begin
      inMark   <= 1'b1;
      idx      <= '0;
      markLat  <= markCycles;
      spaceLat <= spaceCycles;
      fineLat  <= fineCount;
    end else if (inMark) begin
      if (idx == markLast) begin
        inMark <= 1'b0;
        idx    <= '0;
      end else begin
        idx <= idx + CNT_W'(1);
      end
    end else begin
      if (idx == spaceLast) begin
        inMark   <= 1'b1;
        idx      <= '0;
        markLat  <= markCycles;
        spaceLat <= spaceCycles;
        fineLat  <= fineCount;
      end else begin
        idx <= idx + CNT_W'(1);
      end
    end
  end

  always_comb begin
    strb.zeroOut = !enable;
    for (int i = 0; i < PG_LANES; i++) begin
      if (inMark)
        strb.markLane[i] = 1'b1;
      else if (idx == '0)
        strb.markLane[i] = (i < int'(fineLat));
      else
        strb.markLane[i] = 1'b0;
    end
  end

  // R2: a low enable parks the generator at the mark start
  p_restart_r2: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (inMark && idx == '0));
  // R3: mark index never passes the captured length
  p_mark_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    (enable && inMark) |-> (idx <= markLast));
  // R4: space index never passes the captured length
  p_space_bound_r4: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !inMark) |-> (idx <= spaceLast));
  // R5: mark lanes always form a low-side run
  p_fine_thermo_r5: assert property (@(posedge clk) disable iff (!rstN)
    ((strb.markLane & (strb.markLane + PG_LANES'(1))) == '0));
endmodule

// File: rtl/pulse_dp.sv
module pulse_dp
  import pulse_pkg::*;
#(
  parameter int SAMPLE_W = 16
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  pulse_strb_t                  strb,
  input  logic [SAMPLE_W-1:0]          markLevel,
  input  logic [SAMPLE_W-1:0]          spaceLevel,
  output logic [PG_LANES*SAMPLE_W-1:0] sampleWord
);
  for (genvar g = 0; g < PG_LANES; g++) begin : gLane
    always_ff @(posedge clk) begin
      if (!rstN || strb.zeroOut)
        sampleWord[g*SAMPLE_W +: SAMPLE_W] <= '0;
      else if (strb.markLane[g])
        sampleWord[g*SAMPLE_W +: SAMPLE_W] <= markLevel;
      else
        sampleWord[g*SAMPLE_W +: SAMPLE_W] <= spaceLevel;
    end
  end

  // R1: output word is cleared by reset
  p_reset_zero_r1: assert property (@(posedge clk)
    !rstN |=> (sampleWord == '0));
  // R2: a disabled cycle yields an all-zero word
  p_off_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.zeroOut |=> (sampleWord == '0));
endmodule

// File: rtl/pulse_gen_top.sv
module pulse_gen_top
  import pulse_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int CNT_W    = 16,
  localparam int WORD_W  = PG_LANES * SAMPLE_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 enable,
  input  logic [SAMPLE_W-1:0]  markLevel,
  input  logic [SAMPLE_W-1:0]  spaceLevel,
  input  logic [CNT_W-1:0]     markCycles,
  input  logic [CNT_W-1:0]     spaceCycles,
  input  logic [PG_FINE_W-1:0] fineCount,
  output logic [WORD_W-1:0]    sampleWord
);
  pulse_strb_t strb;

  pulse_ctrl #(.CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .enable(enable),
    .markCycles(markCycles), .spaceCycles(spaceCycles),
    .fineCount(fineCount), .strb(strb)
  );

  pulse_dp #(.SAMPLE_W(SAMPLE_W)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .markLevel(markLevel), .spaceLevel(spaceLevel),
    .sampleWord(sampleWord)
  );
endmodule

// File: tb/sim_pulse_gen_top.sv
`timescale 1ns/1ps
module sim_pulse_gen_top;
  localparam int NV = 6;
  localparam int VM [NV] = '{4, 1, 0, 3, 2, 5};
  localparam int VS [NV] = '{2, 3, 0, 1, 5, 4};
  localparam int VF [NV] = '{0, 1, 3, 2, 3, 1};

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b0;
  logic [15:0] markLevel = '0, spaceLevel = '0;
  logic [15:0] markCycles = '0, spaceCycles = '0;
  logic [1:0]  fineCount = '0;
  logic [63:0] sampleWord;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;

  always #2.5 clk = ~clk;

  pulse_gen_top u0 (
    .clk(clk), .rstN(rstN), .enable(enable),
    .markLevel(markLevel), .spaceLevel(spaceLevel),
    .markCycles(markCycles), .spaceCycles(spaceCycles),
    .fineCount(fineCount), .sampleWord(sampleWord)
  );

  function automatic logic [63:0] expWord(int k, int m, int s, int f,
                                          logic [15:0] mk, logic [15:0] sp);
    int me = (m == 0) ? 1 : m;
    int se = (s == 0) ? 1 : s;
    int p  = k % (me + se);
    logic [63:0] w;
    for (int i = 0; i < 4; i++) begin
      if (p < me || (p == me && i < f)) w[i*16 +: 16] = mk;
      else                              w[i*16 +: 16] = sp;
    end
    return w;
  endfunction

  task automatic check(string req, logic [63:0] got, logic [63:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    #200000;
    nFails++;
    $display("FAIL watchdog expired, got running expected finished");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset word", sampleWord, 64'h0);
    rstN = 1'b1;
    @(negedge clk);
    check("R2 idle word", sampleWord, 64'h0);

    // table walk: R3 mark, R4 space/period, R5 fine, R6 zero counts
    for (int v = 0; v < NV; v++) begin
      logic [15:0] mk = 16'hA000 + 16'(v * 16'h0111);
      logic [15:0] sp = 16'h0500 + 16'(v * 16'h0021);
      int me = (VM[v] == 0) ? 1 : VM[v];
      int se = (VS[v] == 0) ? 1 : VS[v];
      enable = 1'b0;
      markLevel = mk; spaceLevel = sp;
      markCycles = 16'(VM[v]); spaceCycles = 16'(VS[v]); fineCount = 2'(VF[v]);
      @(negedge clk);
      check("R2 disabled word", sampleWord, 64'h0);
      enable = 1'b1;
      for (int k = 0; k < 2 * (me + se); k++) begin
        @(negedge clk);
        check("R3/R4/R5/R6 table word", sampleWord,
              expWord(k, VM[v], VS[v], VF[v], mk, sp));
      end
    end

    // R7: count change mid-period is deferred to next mark start
    enable = 1'b0;
    markLevel = 16'h7777; spaceLevel = 16'h1111;
    markCycles = 16'd3; spaceCycles = 16'd2; fineCount = 2'd1;
    @(negedge clk);
    enable = 1'b1;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (k < 5)
        check("R7 first period old counts", sampleWord,
              expWord(k, 3, 2, 1, 16'h7777, 16'h1111));
      else
        check("R7 second period new counts", sampleWord,
              expWord(k - 5, 5, 2, 3, 16'h7777, 16'h1111));
      if (k == 1) begin
        markCycles = 16'd5; fineCount = 2'd3;
      end
    end

    // R7: level change shows on the next word
    enable = 1'b0;
    markCycles = 16'd4; spaceCycles = 16'd4; fineCount = 2'd0;
    @(negedge clk);
    enable = 1'b1;
    @(negedge clk);
    check("R7 level before change", sampleWord, {4{16'h7777}});
    markLevel = 16'h2468;
    @(negedge clk);
    check("R7 live level change", sampleWord, {4{16'h2468}});

    // R8 / R2: one-cycle disable in space, then full mark restart
    repeat (3) @(negedge clk);
    check("R4 space before disable", sampleWord, {4{16'h1111}});
    enable = 1'b0;
    @(negedge clk);
    check("R2 one-cycle disable", sampleWord, 64'h0);
    enable = 1'b1;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      check("R8 restart", sampleWord, expWord(k, 4, 4, 0, 16'h2468, 16'h1111));
    end

    // R1: reset while running
    rstN = 1'b0;
    @(negedge clk);
    check("R1 reset mid-run", sampleWord, 64'h0);
    finishRun();
  end
endmodule